// File: doc/BRIEF.md
# Match-Compare Timer with Watchdog

This block is a memory-mapped timer built around a single free-running counter. The counter advances by one on each cycle in which a tick-enable input is high. That input stands for the base timer clock, nominally 3.6864 MHz, derived elsewhere. Software can also load the counter with any value through the register bus. Four match registers are compared with the counter. When a tick lands the counter on a channel's match value and that channel's interrupt enable is set, the channel's status bit is set and its interrupt line goes high. The line stays high until software clears the bit with a write-one-to-clear access.

Channel 3 also acts as a watchdog. If the watchdog arm bit is set when channel 3 matches, the block emits a one-cycle reset request and disarms itself. This happens whether or not channel 3's interrupt is enabled. The register bus is a plain single-cycle write strobe with a combinational read port. Its offsets are word-aligned: match registers at 0x00, 0x04, 0x08 and 0x0C, the counter at 0x10, status at 0x14, watchdog arm at 0x18 and interrupt enable at 0x1C.

Top module: `match_timer`

## Requirements
- R1: After reset the counter, all match registers, status, interrupt enable and watchdog arm read as zero, and every interrupt line and the reset request are low.
- R2: Each cycle with tick_en high and no counter write adds one to the counter modulo 2^32. Without a tick the counter holds its value.
- R3: A write to offset 0x10 loads the written value into the counter. A load takes precedence over a tick in the same cycle.
- R4: When a tick moves the counter onto match register n and interrupt enable bit n is set, status bit n (bit n of offset 0x14) and irq[n] go high on that same clock edge. irq[n] then stays high while the status bit is set.
- R5: A match sets no status bit when enable bit n is clear. Loading the counter directly with a match value does not count as a match.
- R6: A write to offset 0x14 clears each status bit that is written as one and is currently set, and lowers the matching interrupt line. Bits written as zero are unchanged. If a new match and a clear hit the same bit in one cycle, the bit stays set.
- R7: Offset 0x1C stores only bits 11:0 of a write, and bits 31:12 read back as zero.
- R8: When channel 3 matches while bit 0 of offset 0x18 is set, wdog_rst is high for exactly one cycle, starting at the matching edge. Bit 0 is cleared on that edge, so a later match produces no request until the bit is armed again.
- R9: Reads from any offset outside the map return zero, and writes to such offsets change no register.
- R10: The counter wraps from 0xFFFFFFFF to 0, so a match value behind the current count fires only after the wrap.
- R11: Match registers n = 0 to 3 sit at offset 4*n and read back the last value written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Counter advance enable (base timer clock) |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 4 | Per-channel interrupt lines, level |
| wdog_rst | output | 1 | One-cycle watchdog reset request |

## Verification
The main sweep runs every channel against match distances of one to six ticks, with the other three channels parked far away. It checks that only the targeted line rises, that it rises on exactly the tick that reaches the value, and that it stays high afterwards. Separate patterns test loading the counter straight onto a match value, a disabled channel, and two channels matching together followed by a partial clear. They also cover a clear that coincides with a new match, which separates set-over-clear priority from clear-over-set. The watchdog is run once armed and once disarmed with its interrupt enable off, and a load near the top of the count range exercises the wrap.

// File: rtl/mt_pkg.sv
package mt_pkg;
  typedef logic [7:0] mt_addr_t;

  localparam mt_addr_t OFS_MATCH_BASE = 8'h00;
  localparam mt_addr_t OFS_COUNT      = 8'h10;
  localparam mt_addr_t OFS_STATUS     = 8'h14;
  localparam mt_addr_t OFS_WDOG_ARM   = 8'h18;
  localparam mt_addr_t OFS_IRQ_EN     = 8'h1C;
endpackage

// File: rtl/mt_counter.sv
module mt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             step_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i | tick_i;
    cnt_d  = load_i ? load_val_i : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o     = cnt_q;
  assign cnt_nxt_o = cnt_d;
  assign step_o    = tick_i & ~load_i;

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !load_i) |=> $stable(cnt_q));
  // R2
  cnt_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !load_i) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
  // R3
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(load_val_i)));
endmodule

// File: rtl/mt_match_unit.sv
module mt_match_unit #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  output logic [CNT_W-1:0] match_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] match_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    match_q <= '0;
    else if (wr_i) match_q <= wdata_i;
  end

  assign match_o = match_q;
  assign hit_o   = step_i & (cnt_nxt_i == match_q);
endmodule

// File: rtl/match_timer.sv
module match_timer
  import mt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  parameter int NCH    = 4,
  parameter int IE_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [7:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCH-1:0]    irq,
  output logic              wdog_rst
);
  localparam int WD_CH = NCH - 1;

  // reset release synchronizer
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // write decode
  logic wr_count, wr_status, wr_arm, wr_ie;
  always_comb begin
    wr_count  = bus_wr && (bus_addr == OFS_COUNT);
    wr_status = bus_wr && (bus_addr == OFS_STATUS);
    wr_arm    = bus_wr && (bus_addr == OFS_WDOG_ARM);
    wr_ie     = bus_wr && (bus_addr == OFS_IRQ_EN);
  end

  // counter
  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic             step;

  mt_counter #(.CNT_W(CNT_W)) u_counter (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .tick_i     (tick_en),
    .load_i     (wr_count),
    .load_val_i (bus_wdata[CNT_W-1:0]),
    .cnt_o      (cnt),
    .cnt_nxt_o  (cnt_nxt),
    .step_o     (step)
  );

  // match channels
  logic [CNT_W-1:0] match_val [NCH];
  logic [NCH-1:0]   hit;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam mt_addr_t OFS_I = mt_addr_t'(OFS_MATCH_BASE + 4 * i);
    mt_match_unit #(.CNT_W(CNT_W)) u_match (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .wr_i      (bus_wr && (bus_addr == OFS_I)),
      .wdata_i   (bus_wdata[CNT_W-1:0]),
      .step_i    (step),
      .cnt_nxt_i (cnt_nxt),
      .match_o   (match_val[i]),
      .hit_o     (hit[i])
    );
  end

  // control and status state
  logic [NCH-1:0]  status_q, status_d, clr_mask;
  logic [IE_W-1:0] ie_q;
  logic            arm_q, arm_d;
  logic            wdog_q, wdog_d;
  logic            wd_fire;

  always_comb begin
    clr_mask = wr_status ? bus_wdata[NCH-1:0] : '0;
    status_d = (status_q & ~clr_mask) | (hit & ie_q[NCH-1:0]);
    wd_fire  = hit[WD_CH] & arm_q;
    wdog_d   = wd_fire;
    if (wd_fire)     arm_d = 1'b0;
    else if (wr_arm) arm_d = bus_wdata[0];
    else             arm_d = arm_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      status_q <= '0;
      arm_q    <= 1'b0;
      wdog_q   <= 1'b0;
    end else begin
      status_q <= status_d;
      arm_q    <= arm_d;
      wdog_q   <= wdog_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  ie_q <= '0;
    else if (wr_ie)  ie_q <= bus_wdata[IE_W-1:0];
  end

  assign irq      = status_q;
  assign wdog_rst = wdog_q;

  // read mux
  logic addr_known;
  always_comb begin
    bus_rdata  = '0;
    addr_known = 1'b1;
    case (bus_addr)
      OFS_COUNT:    bus_rdata = DATA_W'(cnt);
      OFS_STATUS:   bus_rdata = DATA_W'(status_q);
      OFS_WDOG_ARM: bus_rdata = DATA_W'(arm_q);
      OFS_IRQ_EN:   bus_rdata = DATA_W'(ie_q);
      default:      addr_known = 1'b0;
    endcase
    for (int i = 0; i < NCH; i++) begin
      if (bus_addr == mt_addr_t'(OFS_MATCH_BASE + 4 * i)) begin
        bus_rdata  = DATA_W'(match_val[i]);
        addr_known = 1'b1;
      end
    end
  end

  // R7
  ie_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_addr == OFS_IRQ_EN) |-> (bus_rdata[DATA_W-1:IE_W] == '0));
  // R9
  unknown_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !addr_known |-> (bus_rdata == '0));
  // R8
  wdog_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    wdog_rst |=> !wdog_rst);
  // R8
  wdog_disarm_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    wdog_rst |-> !arm_q);

  for (genvar n = 0; n < NCH; n++) begin : g_chk
    // R5
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
      $rose(irq[n]) |-> $past(ie_q[n]));
    // R6
    status_clear_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
      (wr_status && bus_wdata[n] && !hit[n]) |=> !irq[n]);
  end
endmodule

// File: tb/match_timer_bench.sv
module match_timer_bench;
  localparam logic [7:0] A_CNT = 8'h10, A_ST = 8'h14, A_ARM = 8'h18, A_IE = 8'h1C;
  localparam logic [31:0] FAR = 32'hDEAD_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq;
  logic        wdog_rst;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  match_timer u_match_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .wdog_rst(wdog_rst)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic tick1();
    @(negedge clk);
    tick_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(8'(a * 4), v);
      chk(v == 0, "R1 reset reg", v, 0);
    end
    chk(irq == 0 && wdog_rst == 0, "R1 outputs", {27'd0, wdog_rst, irq}, 0);

    // R11 match readback
    for (int n = 0; n < 4; n++) wr(8'(4 * n), 32'h1111_0000 * (n + 1) + n);
    for (int n = 0; n < 4; n++) begin
      rd(8'(4 * n), v);
      chk(v == 32'h1111_0000 * (n + 1) + n, "R11 match readback", v, 32'h1111_0000 * (n + 1) + n);
    end

    // R3 load, R2 increment and hold
    wr(A_CNT, 32'd100);
    rd(A_CNT, v); chk(v == 100, "R3 load", v, 100);
    for (int k = 0; k < 5; k++) tick1();
    rd(A_CNT, v); chk(v == 105, "R2 increment", v, 105);
    repeat (3) @(negedge clk);
    rd(A_CNT, v); chk(v == 105, "R2 hold", v, 105);
    @(negedge clk);
    tick_en = 1'b1; bus_wr = 1'b1; bus_addr = A_CNT; bus_wdata = 32'd7000;
    @(negedge clk);
    tick_en = 1'b0; bus_wr = 1'b0;
    rd(A_CNT, v); chk(v == 7000, "R3 load beats tick", v, 7000);

    // R4 sweep over channel and distance
    for (int ch = 0; ch < 4; ch++) begin
      for (int d = 1; d <= 6; d++) begin
        for (int j = 0; j < 4; j++) wr(8'(4 * j), (j == ch) ? 32'(1000 + d) : FAR);
        wr(A_IE, 32'(1 << ch));
        wr(A_CNT, 32'd1000);
        for (int k = 1; k <= d + 2; k++) begin
          tick1();
          chk(irq == ((k >= d) ? 4'(1 << ch) : 4'd0), "R4 match sweep", 32'(irq), (k >= d) ? 32'(1 << ch) : 0);
        end
        rd(A_CNT, v); chk(v == 32'(1000 + d + 2), "R2 sweep count", v, 32'(1000 + d + 2));
        rd(A_ST, v); chk(v == 32'(1 << ch), "R4 status bit", v, 32'(1 << ch));
        wr(A_ST, 32'(1 << ch));
        chk(irq == 0, "R6 clear lowers irq", 32'(irq), 0);
      end
    end

    // R5 load onto match value does not fire; disabled channel does not fire
    wr(8'h00, 32'd500); wr(8'h04, FAR); wr(8'h08, FAR); wr(8'h0C, FAR);
    wr(A_IE, 32'h1);
    wr(A_CNT, 32'd500);
    rd(A_ST, v); chk(v == 0, "R5 load onto match", v, 0);
    tick1();
    chk(irq == 0, "R5 load then tick", 32'(irq), 0);
    wr(A_IE, 32'h0);
    wr(A_CNT, 32'd499);
    tick1();
    rd(A_ST, v); chk(v == 0, "R5 disabled channel", v, 0);

    // R6 partial clear and set-over-clear
    wr(8'h00, 32'd2000); wr(8'h04, 32'd2000);
    wr(A_IE, 32'hF);
    wr(A_CNT, 32'd1999);
    tick1();
    chk(irq == 4'h3, "R4 two channels", 32'(irq), 3);
    wr(A_ST, 32'h6);
    rd(A_ST, v); chk(v == 1, "R6 partial clear", v, 1);
    wr(A_ST, 32'h0);
    rd(A_ST, v); chk(v == 1, "R6 zero write", v, 1);
    wr(A_ST, 32'h1);
    chk(irq == 0, "R6 full clear", 32'(irq), 0);
    wr(A_CNT, 32'd1999);
    @(negedge clk);
    tick_en = 1'b1; bus_wr = 1'b1; bus_addr = A_ST; bus_wdata = 32'h1;
    @(negedge clk);
    tick_en = 1'b0; bus_wr = 1'b0;
    chk(irq == 4'h3, "R6 set wins over clear", 32'(irq), 3);
    wr(A_ST, 32'hF);

    // R7 enable width
    wr(A_IE, 32'hFFFF_FFFF);
    rd(A_IE, v); chk(v == 32'h0000_0FFF, "R7 enable width", v, 32'hFFF);

    // R8 watchdog, irq3 disabled
    wr(A_IE, 32'h0);
    wr(8'h00, FAR); wr(8'h04, FAR); wr(8'h0C, 32'd3003);
    wr(A_ARM, 32'h1);
    rd(A_ARM, v); chk(v == 1, "R8 armed", v, 1);
    wr(A_CNT, 32'd3000);
    for (int k = 1; k <= 5; k++) begin
      tick1();
      chk(wdog_rst == (k == 3), "R8 pulse timing", 32'(wdog_rst), 32'(k == 3));
    end
    rd(A_ARM, v); chk(v == 0, "R8 disarmed", v, 0);
    chk(irq == 0, "R8 no irq when disabled", 32'(irq), 0);
    wr(A_CNT, 32'd3000);
    for (int k = 1; k <= 4; k++) begin
      tick1();
      chk(wdog_rst == 0, "R8 no repeat", 32'(wdog_rst), 0);
    end

    // R9 unknown offsets
    wr(8'h20, 32'hFFFF_FFFF); wr(8'h24, 32'hFFFF_FFFF); wr(8'h11, 32'hFFFF_FFFF);
    rd(8'h20, v); chk(v == 0, "R9 unknown read", v, 0);
    rd(8'h11, v); chk(v == 0, "R9 unaligned read", v, 0);
    rd(8'h0C, v); chk(v == 3003, "R9 no side effect", v, 3003);
    rd(A_CNT, v); chk(v == 3004, "R9 counter untouched", v, 3004);

    // R10 wrap
    wr(8'h00, 32'd1); wr(8'h04, 32'hFFFF_FFF0); wr(8'h0C, FAR);
    wr(A_IE, 32'h3);
    wr(A_CNT, 32'hFFFF_FFFE);
    tick1(); tick1();
    rd(A_CNT, v); chk(v == 0, "R10 wrap to zero", v, 0);
    chk(irq == 0, "R10 before match", 32'(irq), 0);
    tick1();
    chk(irq == 4'h1, "R10 after wrap", 32'(irq), 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule